// File: doc/BRIEF.md
# One-Time-Programmable Fuse Word Reader

This block lets a bus host fetch 32-bit words from a one-time-programmable fuse array. The host picks a word by writing its index into a control register and then issues a read command. The block then runs a timed access to the fuse array. It waits for a relax interval, pulses the fuse strobe for a programmable width, and waits for a second relax interval. It then latches the word into a read-data register and lowers busy. The control register can be written directly, or updated through a set alias (bitwise OR) and a clear alias (bitwise AND-NOT), so software can change single flags without a read-modify-write.

A read never aborts. If the command arrives at a bad moment, or names a word beyond the array, the error flag rises and the data register holds the poison word 0xBADABADA in place of fuse contents. The fuse array is modelled inside the block as an array of registers loaded at reset with a computed pattern. The host clears the error flag through the clear alias.

Top module: `otp_fuse_reader`

## Requirements
- R1: After reset the control, timing, program-data and read-data registers all read 0, and `busy` and `fuse_strobe` are low.
- R2: A write at offset 0x00 stores word index bits 6:0, error bit 9, reload bit 10 and unlock field 31:16. All other bits read 0. Bit 8 reads the live busy state, and no write to any control offset changes it.
- R3: A write at offset 0x04 ORs the write data into the writable control bits. A write at offset 0x08 clears every writable control bit that is 1 in the write data.
- R4: The timing register at offset 0x10 keeps bits 21:0: read-strobe count in 21:16, relax count in 15:12 and program-strobe count in 11:0. Its upper bits read 0. The program-data register at 0x20 keeps all 32 bits.
- R5: A write at offset 0x30 with bit 0 set starts a read, provided busy and error are both low. `busy` then stays high for 2*relax + strobe + 3 cycles. `fuse_strobe` is high for strobe + 1 of those cycles and never outside busy.
- R6: A write at offset 0x30 with bit 0 clear starts nothing.
- R7: A successful read loads offset 0x40 with the fuse word at index i, which is {8'h5A, i[7:0], 8'h00, ~i[7:0]}, and leaves error at 0.
- R8: A read of an index at or above the array depth (64) sets error and loads 0xBADABADA.
- R9: A read command issued while busy or error is set starts no new sequence. It sets error and leaves the read-data register holding 0xBADABADA.
- R10: A bus read returns data one clock after `bus_rd` is sampled. Offset 0x30 and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| busy | output | 1 | Read sequence in progress |
| fuse_strobe | output | 1 | Strobe pulse to the fuse array |

## Verification
The bench sweeps indices and timing values, including a zero relax/strobe setting and the maximum setting, and measures the busy and strobe widths. An off-by-one counter would show up as a width one cycle short or long. The indices 63 and 64 sit on either side of the array edge: a design with a loose bound would hand back a wrapped fuse word without flagging an error. A command sent mid-sequence, or while error is already set, must leave poison and must not restart the sequence. A design that re-armed would show a second busy period or real fuse data. The alias writes are also checked against bit 8, since a design that let busy be written would report busy with no sequence running.

// File: rtl/otp_fuse_reader.sv
module otp_fuse_reader #(
  parameter int FUSE_DEPTH = 64,
  parameter logic [31:0] BAD_WORD = 32'hBADA_BADA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        busy,
  output logic        fuse_strobe
);
  localparam int IW = (FUSE_DEPTH > 1) ? $clog2(FUSE_DEPTH) : 1;
  localparam logic [7:0] A_CTRL = 8'h00, A_SET = 8'h04, A_CLR = 8'h08,
                         A_TIME = 8'h10, A_PDAT = 8'h20, A_CMD = 8'h30, A_RDAT = 8'h40;

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_STB, S_POST} st_t;

  function automatic logic [31:0] fuse_pattern(input int i);
    logic [7:0] b;
    b = i[7:0];
    return {8'h5A, b, 8'h00, ~b};
  endfunction

  logic [31:0] fuse_mem [FUSE_DEPTH];
  logic [6:0]  addr_q;
  logic        err_q, reload_q;
  logic [15:0] unlock_q;
  logic [21:0] timing_q;
  logic [31:0] pdat_q, data_q;
  st_t         st_q;
  logic [5:0]  cnt_q, lim;
  logic [3:0]  relax_l;
  logic [5:0]  rstb_l;
  logic [6:0]  fa_q;
  logic [31:0] ctrl_view, ctrl_st, ctrl_nxt;
  logic        cmd_go, cmd_ok, cmd_bad, cap, oor, err_set;

  assign busy        = (st_q != S_IDLE);
  assign fuse_strobe = (st_q == S_STB);
  assign ctrl_view   = {unlock_q, 5'b0, reload_q, err_q, busy, 1'b0, addr_q};
  assign ctrl_st     = {unlock_q, 5'b0, reload_q, err_q, 1'b0, 1'b0, addr_q};

  assign cmd_go  = bus_wr && (bus_addr == A_CMD) && bus_wdata[0];
  assign cmd_ok  = cmd_go && !busy && !err_q;
  assign cmd_bad = cmd_go && (busy || err_q);
  assign lim     = (st_q == S_STB) ? rstb_l : {2'b00, relax_l};
  assign cap     = (st_q == S_POST) && (cnt_q == lim);
  assign oor     = ({25'd0, fa_q} >= FUSE_DEPTH);
  assign err_set = cmd_bad || (cap && oor);

  always_comb begin
    ctrl_nxt = ctrl_st;
    if (bus_wr) begin
      case (bus_addr)
        A_CTRL:  ctrl_nxt = bus_wdata;
        A_SET:   ctrl_nxt = ctrl_st | bus_wdata;
        A_CLR:   ctrl_nxt = ctrl_st & ~bus_wdata;
        default: ctrl_nxt = ctrl_st;
      endcase
    end
    if (err_set) ctrl_nxt[9] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= '0;
      err_q    <= 1'b0;
      reload_q <= 1'b0;
      unlock_q <= '0;
    end else begin
      addr_q   <= ctrl_nxt[6:0];
      err_q    <= ctrl_nxt[9];
      reload_q <= ctrl_nxt[10];
      unlock_q <= ctrl_nxt[31:16];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timing_q <= '0;
      pdat_q   <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_TIME) timing_q <= bus_wdata[21:0];
      if (bus_addr == A_PDAT) pdat_q   <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < FUSE_DEPTH; i++) fuse_mem[i] <= fuse_pattern(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      cnt_q   <= '0;
      relax_l <= '0;
      rstb_l  <= '0;
      fa_q    <= '0;
    end else if (cmd_ok) begin
      st_q    <= S_PRE;
      cnt_q   <= '0;
      relax_l <= timing_q[15:12];
      rstb_l  <= timing_q[21:16];
      fa_q    <= addr_q;
    end else if (st_q != S_IDLE) begin
      if (cnt_q == lim) begin
        cnt_q <= '0;
        case (st_q)
          S_PRE:   st_q <= S_STB;
          S_STB:   st_q <= S_POST;
          default: st_q <= S_IDLE;
        endcase
      end else begin
        cnt_q <= cnt_q + 6'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) data_q <= '0;
    else if (cmd_bad) data_q <= BAD_WORD;
    else if (cap) data_q <= (err_q || oor) ? BAD_WORD : fuse_mem[fa_q[IW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        A_CTRL, A_SET, A_CLR: bus_rdata <= ctrl_view;
        A_TIME:  bus_rdata <= {10'd0, timing_q};
        A_PDAT:  bus_rdata <= pdat_q;
        A_RDAT:  bus_rdata <= data_q;
        default: bus_rdata <= '0;
      endcase
    end
  end

  a_r5_strobe_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_strobe |-> busy);
  a_r5_cmd_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && !busy && !err_q) |=> busy);
  a_r9_bad_cmd_err: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && (busy || err_q)) |=> err_q);
  a_r2_busy_only_by_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_go));
  a_r8_poison_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && $past(err_q)) |-> (data_q == BAD_WORD));
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q <= lim));
endmodule

// File: tb/tb_otp_fuse_reader.sv
module tb_otp_fuse_reader;
  localparam logic [31:0] BAD = 32'hBADA_BADA;
  localparam int NV = 7;
  // {index[6:0], relax[3:0], strobe[5:0]}
  localparam logic [16:0] VEC [NV] = '{
    {7'd0,   4'd0,  6'd0},
    {7'd5,   4'd1,  6'd2},
    {7'd17,  4'd3,  6'd7},
    {7'd63,  4'd2,  6'd1},
    {7'd64,  4'd0,  6'd0},
    {7'd127, 4'd1,  6'd1},
    {7'd40,  4'd15, 6'd63}
  };

  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic busy, fuse_strobe;
  int n_chk = 0, n_bad = 0;
  logic [31:0] v;

  otp_fuse_reader dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .fuse_strobe(fuse_strobe));

  always #10 clk = ~clk;

  function automatic logic [31:0] pat(input int i);
    logic [7:0] b;
    b = i[7:0];
    return {8'h5A, b, 8'h00, ~b};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic wait_idle(output int nb, output int ns);
    nb = 0; ns = 0;
    while (busy) begin
      nb++;
      if (fuse_strobe) ns++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int nb, ns;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 strobe", {31'd0, fuse_strobe}, 0);
    rd(8'h00, v); chk("R1 ctrl", v, 0);
    rd(8'h10, v); chk("R1 timing", v, 0);
    rd(8'h20, v); chk("R1 pdata", v, 0);
    rd(8'h40, v); chk("R1 rdata", v, 0);

    // R2 direct control write
    wr(8'h00, 32'hFFFF_FFFF);
    chk("R2 busy not writable", {31'd0, busy}, 0);
    rd(8'h00, v); chk("R2 ctrl fields", v, 32'hFFFF_067F);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h00, v); chk("R3 clear all", v, 0);

    // R3 aliases
    wr(8'h04, 32'h0000_0405);
    rd(8'h00, v); chk("R3 set", v, 32'h0000_0405);
    wr(8'h04, 32'h3E77_0002);
    rd(8'h00, v); chk("R3 set or", v, 32'h3E77_0407);
    wr(8'h08, 32'h0000_0401);
    rd(8'h00, v); chk("R3 clear", v, 32'h3E77_0006);
    wr(8'h04, 32'h0000_0100);
    chk("R2 set busy ignored", {31'd0, busy}, 0);
    rd(8'h00, v); chk("R2 ctrl after set bit8", v, 32'h3E77_0006);

    // R4 timing and program data
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, v); chk("R4 timing mask", v, 32'h003F_FFFF);
    wr(8'h20, 32'h1234_5678);
    rd(8'h20, v); chk("R4 pdata", v, 32'h1234_5678);

    // R10 read-control and unmapped read as zero
    rd(8'h30, v); chk("R10 cmd reads 0", v, 0);
    rd(8'h7C, v); chk("R10 unmapped", v, 0);

    // R6 command without bit 0
    wr(8'h30, 32'h0000_0002);
    chk("R6 no start", {31'd0, busy}, 0);
    rd(8'h40, v); chk("R6 data untouched", v, 0);

    // Table walk: R5 R7 R8
    for (int k = 0; k < NV; k++) begin
      logic [6:0] ix; logic [3:0] rx; logic [5:0] sx; logic oob;
      {ix, rx, sx} = VEC[k];
      oob = (ix >= 7'd64);
      wr(8'h10, {10'd0, sx, rx, 12'h000});
      wr(8'h00, {25'd0, ix});
      wr(8'h30, 32'h1);
      wait_idle(nb, ns);
      chk("R5 busy width", nb, 2 * rx + sx + 3);
      chk("R5 strobe width", ns, sx + 1);
      rd(8'h40, v);
      chk(oob ? "R8 poison" : "R7 fuse word", v, oob ? BAD : pat(ix));
      rd(8'h00, v);
      chk(oob ? "R8 error set" : "R7 error clear", {31'd0, v[9]}, {31'd0, oob});
      if (oob) wr(8'h08, 32'h0000_0200);
    end

    // R9 command during busy
    wr(8'h10, {10'd0, 6'd3, 4'd2, 12'h000});
    wr(8'h00, 32'd3);
    wr(8'h30, 32'h1);
    rd(8'h00, v); chk("R2 busy bit visible", {31'd0, v[8]}, 1);
    wr(8'h30, 32'h1);
    rd(8'h00, v); chk("R9 err on busy cmd", {31'd0, v[9]}, 1);
    wait_idle(nb, ns);
    chk("R9 no restart", nb, 2 * 2 + 3 + 3 - 6);
    rd(8'h40, v); chk("R9 poison after busy cmd", v, BAD);
    wr(8'h08, 32'h0000_0200);

    // R9 command while error set
    wr(8'h00, 32'd4);
    wr(8'h30, 32'h1);
    wait_idle(nb, ns);
    rd(8'h40, v); chk("R7 good before err test", v, pat(4));
    wr(8'h04, 32'h0000_0200);
    wr(8'h30, 32'h1);
    chk("R9 no start with err", {31'd0, busy}, 0);
    rd(8'h40, v); chk("R9 poison with err", v, BAD);
    wr(8'h08, 32'h0000_0200);
    rd(8'h00, v); chk("R3 err cleared", {31'd0, v[9]}, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule